// File: doc/BRIEF.md
# Single-Shot Down-Count Output Timer

The block is one 16-bit one-shot timer channel. A start comes from an external trigger pin or from a write of 1 to the enable bit. It arms a down-counter that is clocked by an internal programmable prescaler tick. The first tick after the start loads the counter from the reload input and inverts the pulse output. Each later tick decrements the counter. A tick that finds the counter at zero is an underflow. An underflow inverts the output again, stops the channel and raises an interrupt request, so each start produces exactly one output pulse.

Software can also stop the channel with a write of 0 to the enable bit. It can add a correction value to the live count. A correction that wraps past 0xFFFF raises no flag. When start, stop and underflow land in the same clock cycle, fixed priority rules decide the outcome.

Top module: `oneshot_timer`

## Requirements
- R1: After reset `count_o` is 0x0000, and `running_o`, `pulse_o`, `irq_o` and `irq_sts_o` are all 0.
- R2: A start arms the channel from the next clock. A start is `trig_i` high, or an enable write (`en_wr_i`=1, `en_val_i`=1), while idle. The prescaler ticks every `div_i`+1 clocks, with its phase restarted at the start. The first tick comes `div_i`+1 clocks after the start edge. It loads `reload_i` into the count and inverts `pulse_o`.
- R3: Each later tick decrements the count. A tick at count 0x0000 is an underflow: the count becomes 0xFFFF, `pulse_o` inverts and `running_o` clears. The pulse therefore lasts (`div_i`+1)·(`reload_i`+1) clocks. The count changes only on a tick or a correction write.
- R4: On the clock after an underflow edge, `irq_o` is high for exactly one cycle and `irq_sts_o` sets. `irq_sts_o` stays set until `sts_clr_i` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R5: An underflow and `trig_i` in the same cycle: the channel stops and the trigger is lost.
- R6: An underflow and an enable write of 1 in the same cycle: the channel keeps running and counts down from 0xFFFF without reloading. The underflow still inverts `pulse_o` and raises `irq_o`.
- R7: `trig_i` together with an enable write of 0 in the same cycle leaves the channel idle. `pulse_o` and the count are unchanged.
- R8: An enable write of 0 stops the channel at once. Any tick due in that cycle is dropped. The count freezes and `pulse_o` keeps its level.
- R9: A correction write (`corr_wr_i`) adds `corr_i` to the count modulo 2^16. The addition includes any decrement in the same cycle, so 0xFFF0 corrected by 0x0014 on a tick gives 0x0003. A wrap caused by a correction never raises `irq_o`. The later underflow of the wrapped count does raise it.
- R10: While running, `trig_i` and enable writes of 1 have no effect, and the count keeps decrementing without reloading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | External start request |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_val_i | input | 1 | Value written to the enable bit |
| corr_wr_i | input | 1 | Write strobe for the correction value |
| corr_i | input | 16 | Correction added to the count |
| reload_i | input | 16 | Value loaded on the first tick after a start |
| div_i | input | 8 | Prescaler divisor; tick every div_i+1 clocks |
| sts_clr_i | input | 1 | Clears the interrupt status bit |
| count_o | output | 16 | Current count |
| running_o | output | 1 | Enable bit / channel counting |
| pulse_o | output | 1 | Toggle flip-flop output |
| irq_o | output | 1 | One-cycle underflow interrupt request |
| irq_sts_o | output | 1 | Sticky underflow status |

## Verification
The hardest situations to reach are the same-cycle collisions. In these a trigger or an enable write has to land on exactly the clock edge where the counter underflows. The bench computes that edge arithmetically as (div+1)·(reload+2) clocks after the start edge and drives the colliding strobe in the cycle before it. The same counting places a correction write on a tick where the count is 0xFFF0, which forces the silent wrap. A sweep over small divisors and reload values then checks the pulse delay, the pulse width and the interrupt timing against the same formulas.

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          en_wr_i,
  input  logic          en_val_i,
  input  logic          corr_wr_i,
  input  logic [CW-1:0] corr_i,
  input  logic [CW-1:0] reload_i,
  input  logic [PW-1:0] div_i,
  input  logic          sts_clr_i,
  output logic [CW-1:0] count_o,
  output logic          running_o,
  output logic          pulse_o,
  output logic          irq_o,
  output logic          irq_sts_o
);

  logic          run, fresh, ff, irq, sts;
  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;

  wire sw_on  = en_wr_i && en_val_i;
  wire sw_off = en_wr_i && !en_val_i;
  wire tick   = run && !sw_off && (pre >= div_i);
  wire load   = tick && fresh;
  wire dec    = tick && !fresh;
  wire uf     = dec && (cnt == '0);
  wire go     = !run && !sw_off && (sw_on || trig_i);

  wire [CW-1:0] add = corr_wr_i ? corr_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      fresh <= 1'b0;
      pre   <= '0;
      cnt   <= '0;
      ff    <= 1'b0;
      irq   <= 1'b0;
      sts   <= 1'b0;
    end else begin
      if (sw_off)     run <= 1'b0;
      else if (sw_on) run <= 1'b1;
      else if (uf)    run <= 1'b0;
      else if (trig_i) run <= 1'b1;

      if (sw_off)    fresh <= 1'b0;
      else if (go)   fresh <= 1'b1;
      else if (tick) fresh <= 1'b0;

      pre <= (run && !tick && !sw_off) ? pre + 1'b1 : '0;

      if (load) cnt <= reload_i;
      else      cnt <= cnt + add - CW'(dec);

      if (load || uf) ff <= ~ff;

      irq <= uf;
      sts <= uf | (sts & ~sts_clr_i);
    end
  end

  assign count_o   = cnt;
  assign running_o = run;
  assign pulse_o   = ff;
  assign irq_o     = irq;
  assign irq_sts_o = sts;

  // R3
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !corr_wr_i) |=> $stable(count_o));

  // R3
  ff_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pulse_o));

  // R8
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_off |=> !running_o);

  // R5
  uf_over_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && trig_i && !en_wr_i) |=> !running_o);

  // R6
  en_over_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && sw_on) |=> (running_o && count_o == {CW{1'b1}} + $past(add)));

  // R4
  irq_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_sts_o);

  // R9
  no_wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec |=> !irq_o);

endmodule

// File: tb/oneshot_timer_bench.sv
`timescale 1ns/1ps
module oneshot_timer_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        trig_i = 0, en_wr_i = 0, en_val_i = 0, corr_wr_i = 0, sts_clr_i = 0;
  logic [15:0] corr_i = 0, reload_i = 0;
  logic [7:0]  div_i = 0;
  logic [15:0] count_o;
  logic        running_o, pulse_o, irq_o, irq_sts_o;

  oneshot_timer u_oneshot_timer (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .en_wr_i(en_wr_i), .en_val_i(en_val_i),
    .corr_wr_i(corr_wr_i), .corr_i(corr_i), .reload_i(reload_i), .div_i(div_i),
    .sts_clr_i(sts_clr_i), .count_o(count_o), .running_o(running_o), .pulse_o(pulse_o),
    .irq_o(irq_o), .irq_sts_o(irq_sts_o));

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 count", count_o, 0);
    chk("R1 running", running_o, 0);
    chk("R1 pulse", pulse_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 sts", irq_sts_o, 0);
  endtask

  task automatic start(input bit ext);
    @(negedge clk);
    if (ext) trig_i = 1; else begin en_wr_i = 1; en_val_i = 1; end
    @(negedge clk);
    trig_i = 0; en_wr_i = 0; en_val_i = 0;
  endtask

  task automatic run_one(input int dv, input int rl, input bit ext);
    int first, hi, irqk, irqn, ufk;
    first = -1; hi = 0; irqk = -1; irqn = 0;
    ufk = (dv + 1) * (rl + 2);
    div_i = 8'(dv); reload_i = 16'(rl);
    start(ext);
    chk("R2 running after start", running_o, 1);
    for (int k = 0; k <= ufk + 3; k++) begin
      if (pulse_o) begin if (first < 0) first = k; hi++; end
      if (irq_o) begin irqn++; irqk = k; end
      if (k == dv + 1) chk("R2 load value", count_o, rl);
      @(negedge clk);
    end
    chk("R2 pulse delay", first, dv + 1);
    chk("R3 pulse width", hi, (dv + 1) * (rl + 1));
    chk("R3 end count", count_o, 16'hFFFF);
    chk("R3 stopped", running_o, 0);
    chk("R4 irq cycle", irqk, ufk);
    chk("R4 irq count", irqn, 1);
    chk("R4 sts held", irq_sts_o, 1);
    sts_clr_i = 1; @(negedge clk); sts_clr_i = 0;
    chk("R4 sts cleared", irq_sts_o, 0);
  endtask

  initial begin
    int ufk, ir;
    do_reset();

    for (int d = 0; d < 4; d++)
      for (int r = 0; r < 5; r++)
        run_one(d, r, ((d + r) % 2) == 1);

    // R5: underflow with trigger
    div_i = 1; reload_i = 2; ufk = 2 * 4;
    start(0);
    repeat (ufk - 1) @(negedge clk);
    trig_i = 1; @(negedge clk); trig_i = 0;
    chk("R5 stopped", running_o, 0);
    chk("R5 irq", irq_o, 1);
    chk("R5 count", count_o, 16'hFFFF);
    repeat (6) @(negedge clk);
    chk("R5 still idle", running_o, 0);
    chk("R5 count held", count_o, 16'hFFFF);
    chk("R5 pulse low", pulse_o, 0);

    // R6: underflow with enable write
    start(0);
    repeat (ufk - 1) @(negedge clk);
    en_wr_i = 1; en_val_i = 1; @(negedge clk); en_wr_i = 0; en_val_i = 0;
    chk("R6 running", running_o, 1);
    chk("R6 count", count_o, 16'hFFFF);
    chk("R6 irq", irq_o, 1);
    chk("R6 pulse inverted", pulse_o, 0);
    repeat (2) @(negedge clk);
    chk("R6 continues", count_o, 16'hFFFE);
    en_wr_i = 1; en_val_i = 0; @(negedge clk); en_wr_i = 0;
    chk("R8 stop", running_o, 0);
    chk("R8 count frozen", count_o, 16'hFFFE);

    // R7: trigger with disable write
    trig_i = 1; en_wr_i = 1; en_val_i = 0; @(negedge clk);
    trig_i = 0; en_wr_i = 0;
    repeat (4) @(negedge clk);
    chk("R7 idle", running_o, 0);
    chk("R7 pulse", pulse_o, 0);
    chk("R7 count", count_o, 16'hFFFE);

    // R8: stop mid-pulse
    div_i = 0; reload_i = 20;
    start(0);
    repeat (5) @(negedge clk);
    chk("R8 pre-stop count", count_o, 16);
    en_wr_i = 1; en_val_i = 0; @(negedge clk); en_wr_i = 0;
    chk("R8 tick dropped", count_o, 16);
    chk("R8 running", running_o, 0);
    chk("R8 pulse kept", pulse_o, 1);
    repeat (4) @(negedge clk);
    chk("R8 frozen", count_o, 16);
    do_reset();

    // R9: correction wrap
    div_i = 0; reload_i = 16'hFFF8;
    start(1);
    repeat (9) @(negedge clk);
    chk("R9 pre-corr count", count_o, 16'hFFF0);
    corr_wr_i = 1; corr_i = 16'h0014; @(negedge clk); corr_wr_i = 0;
    chk("R9 wrapped count", count_o, 16'h0003);
    chk("R9 no irq on wrap", irq_o, 0);
    ir = 0;
    for (int k = 10; k < 14; k++) begin
      if (irq_o) ir++;
      @(negedge clk);
    end
    chk("R9 no early irq", ir, 0);
    chk("R9 underflow irq", irq_o, 1);
    chk("R9 pulse low", pulse_o, 0);
    corr_wr_i = 1; corr_i = 16'h0002; @(negedge clk); corr_wr_i = 0;
    chk("R9 idle wrap", count_o, 16'h0001);
    chk("R9 idle wrap irq", irq_o, 0);

    // R10: starts ignored while running
    div_i = 0; reload_i = 20;
    start(0);
    repeat (3) @(negedge clk);
    chk("R10 count", count_o, 18);
    trig_i = 1; @(negedge clk); trig_i = 0;
    chk("R10 trig ignored", count_o, 17);
    en_wr_i = 1; en_val_i = 1; @(negedge clk); en_wr_i = 0; en_val_i = 0;
    chk("R10 enable ignored", count_o, 16);
    repeat (22) @(negedge clk);
    chk("R10 finished", running_o, 0);
    chk("R10 pulse low", pulse_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule